// File: doc/BRIEF.md
# System Register Bank with Pseudo-GPIO Words

This block is a small memory-mapped bank of 32-bit words for board housekeeping. A host reaches it over a plain single-cycle bus with an address, a write enable, write data and read data. The bank holds a board identification word, an eight-bit user LED output word, a 32-bit flag word with separate set and clear write addresses, a card-status word, a flash write-protect control word and a miscellaneous word that reports which daughterboard site is master.

Several words act as tiny GPIO ports. Some bits are outputs that drive pins and can be read back. Others are read-only images of input pins that pass through a synchroniser before they reach the read path. Reads are combinational from the addressed word. A write updates its register on the next rising clock edge.

Top module: `sysreg_bank`

## Requirements
- R1: While reset is asserted and directly after it, the LED pins, the flag word and the flash control bit are all zero. A zero flash control bit means flash is write-protected.
- R2: Offset 0x000 reads the board number from the synchronised board pins in bits starting at bit 16, with the fixed identifier parameter (default 0x0100) in bits 15:0 and zeros above the board field. Writes to it are ignored.
- R3: A write to offset 0x008 stores data bits 7:0. LED pin n follows stored bit n. A read returns the stored byte in bits 7:0 and zeros above.
- R4: A write to offset 0x030 sets every flag bit whose data bit is 1 and leaves the other flags unchanged. Reading offset 0x030 returns the flag word.
- R5: A write to offset 0x034 clears every flag bit whose data bit is 1, so all ones clears every flag. Offset 0x034 reads as zero.
- R6: Offset 0x048 reads the synchronised card-present pin in bit 0 and the card write-protect pin in bit 1, with zeros above. A pin change becomes visible after exactly two rising edges. Writes to this offset are ignored.
- R7: A write to offset 0x04C stores data bit 0 as the active-low flash write-protect control, which drives the flash pin. The read returns it in bit 0 with zeros above.
- R8: Offset 0x060 reads the synchronised master-site pin in bit 14: 1 means the second daughterboard site is master and 0 means the first. All other bits read zero, and writes are ignored.
- R9: Unmapped and unaligned offsets read as zero. Writes to them change no register.
- R10: When a read and a write target the same offset in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte offset of the accessed word |
| busWe | input | 1 | Write strobe for the current cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| boardNumIn | input | 12 | Board number pins |
| cardPresentIn | input | 1 | Card-present pin |
| cardWpIn | input | 1 | Card write-protect pin |
| masterSiteIn | input | 1 | Master-site select pin |
| ledOut | output | 8 | User LED pins |
| flashWpN | output | 1 | Active-low flash write-protect pin |

## Verification
The flag word is driven with overlapping set patterns, partial clears and an all-ones clear. These show that set and clear each act only on the selected bits and that one port does not behave like the other. LED and flash words receive data with set upper bits, which shows that only the defined bits are stored and read back. The read-only words, unmapped offsets and unaligned offsets receive all-ones writes followed by reads, together with a check on a neighbouring register, to show that nothing leaks. Pins are toggled and sampled edge by edge to fix the two-edge synchroniser latency, and a write with a read of the same address shows that the read returns the value held before the write.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  // Word offsets (byte addresses) that software decodes
  localparam logic [11:0] OFS_ID       = 12'h000;
  localparam logic [11:0] OFS_LED      = 12'h008;
  localparam logic [11:0] OFS_FLAG_SET = 12'h030;
  localparam logic [11:0] OFS_FLAG_CLR = 12'h034;
  localparam logic [11:0] OFS_CARD     = 12'h048;
  localparam logic [11:0] OFS_FLASH    = 12'h04C;
  localparam logic [11:0] OFS_MISC     = 12'h060;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_LED,
    SEL_FLAGS,
    SEL_CARD,
    SEL_FLASH,
    SEL_MISC
  } rdSel_e;

  typedef struct packed {
    logic   ledWr;
    logic   flagSet;
    logic   flagClr;
    logic   flashWr;
    rdSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/sysreg_sync.sv
module sysreg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/sysreg_ctrl.sv
module sysreg_ctrl
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output busStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_LED   = ADDR_W'(OFS_LED);
  localparam logic [ADDR_W-1:0] A_FSET  = ADDR_W'(OFS_FLAG_SET);
  localparam logic [ADDR_W-1:0] A_FCLR  = ADDR_W'(OFS_FLAG_CLR);
  localparam logic [ADDR_W-1:0] A_CARD  = ADDR_W'(OFS_CARD);
  localparam logic [ADDR_W-1:0] A_FLASH = ADDR_W'(OFS_FLASH);
  localparam logic [ADDR_W-1:0] A_MISC  = ADDR_W'(OFS_MISC);

  rdSel_e sel;

  always_comb begin
    case (busAddr)
      A_ID:    sel = SEL_ID;
      A_LED:   sel = SEL_LED;
      A_FSET:  sel = SEL_FLAGS;
      A_CARD:  sel = SEL_CARD;
      A_FLASH: sel = SEL_FLASH;
      A_MISC:  sel = SEL_MISC;
      default: sel = SEL_NONE;   // includes clear port: reads zero
    endcase
  end

  always_comb begin
    strobe.rdSel   = sel;
    strobe.ledWr   = busWe && (busAddr == A_LED);
    strobe.flagSet = busWe && (busAddr == A_FSET);
    strobe.flagClr = busWe && (busAddr == A_FCLR);
    strobe.flashWr = busWe && (busAddr == A_FLASH);
  end

endmodule

// File: rtl/sysreg_datapath.sv
module sysreg_datapath
  import sysreg_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          LED_W       = 8,
  parameter int          BOARD_W     = 12,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] ID_LOW      = 16'h0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [BOARD_W-1:0] boardNumIn,
  input  logic               cardPresentIn,
  input  logic               cardWpIn,
  input  logic               masterSiteIn,
  output logic [LED_W-1:0]   ledOut,
  output logic               flashWpN
);

  localparam int BOARD_LSB  = 16;
  localparam int MASTER_BIT = 14;
  localparam int PIN_W      = BOARD_W + 3;

  logic [LED_W-1:0]  ledReg;
  logic [DATA_W-1:0] flagReg;
  logic              flashReg;
  logic [PIN_W-1:0]  pinsSync;
  logic [BOARD_W-1:0] boardSync;
  logic [1:0]        cardSync;
  logic              masterSync;

  sysreg_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({boardNumIn, masterSiteIn, cardWpIn, cardPresentIn}),
    .syncOut (pinsSync)
  );

  assign {boardSync, masterSync, cardSync} = pinsSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledReg   <= '0;
      flashReg <= 1'b0;
    end else begin
      if (strobe.ledWr)   ledReg   <= wrData[LED_W-1:0];
      if (strobe.flashWr) flashReg <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flagReg <= '0;
    else if (strobe.flagSet) flagReg <= flagReg | wrData;
    else if (strobe.flagClr) flagReg <= flagReg & ~wrData;
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      SEL_ID: begin
        rdData[15:0] = ID_LOW;
        rdData[BOARD_LSB +: BOARD_W] = boardSync;
      end
      SEL_LED:   rdData[LED_W-1:0] = ledReg;
      SEL_FLAGS: rdData = flagReg;
      SEL_CARD:  rdData[1:0] = cardSync;
      SEL_FLASH: rdData[0] = flashReg;
      SEL_MISC:  rdData[MASTER_BIT] = masterSync;
      default:   rdData = '0;
    endcase
  end

  assign ledOut   = ledReg;
  assign flashWpN = flashReg;

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          LED_W       = 8,
  parameter int          BOARD_W     = 12,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] ID_LOW      = 16'h0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [BOARD_W-1:0] boardNumIn,
  input  logic               cardPresentIn,
  input  logic               cardWpIn,
  input  logic               masterSiteIn,
  output logic [LED_W-1:0]   ledOut,
  output logic               flashWpN
);

  busStrobe_t strobe;

  sysreg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe)
  );

  sysreg_datapath #(
    .DATA_W      (DATA_W),
    .LED_W       (LED_W),
    .BOARD_W     (BOARD_W),
    .SYNC_STAGES (SYNC_STAGES),
    .ID_LOW      (ID_LOW)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (busWrData),
    .rdData        (busRdData),
    .boardNumIn    (boardNumIn),
    .cardPresentIn (cardPresentIn),
    .cardWpIn      (cardWpIn),
    .masterSiteIn  (masterSiteIn),
    .ledOut        (ledOut),
    .flashWpN      (flashWpN)
  );

endmodule

// File: rtl/sysreg_bank_checker.sv
module sysreg_bank_checker
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LED_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [LED_W-1:0]  ledOut,
  input logic              flashWpN
);

  logic atLed, atFlash, atCard, atMisc, mapped;
  assign atLed   = busAddr == ADDR_W'(OFS_LED);
  assign atFlash = busAddr == ADDR_W'(OFS_FLASH);
  assign atCard  = busAddr == ADDR_W'(OFS_CARD);
  assign atMisc  = busAddr == ADDR_W'(OFS_MISC);
  assign mapped  = atLed || atFlash || atCard || atMisc
                || busAddr == ADDR_W'(OFS_ID)
                || busAddr == ADDR_W'(OFS_FLAG_SET);

  p_reset_outputs_r1: assert property (@(posedge clk)
    !rstN |-> (ledOut == '0 && flashWpN == 1'b0));

  p_led_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && atLed) |=> ledOut == $past(busWrData[LED_W-1:0]));

  p_led_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && atLed) |=> $stable(ledOut));

  p_card_upper_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    atCard |-> busRdData[DATA_W-1:2] == '0);

  p_flash_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && atFlash) |=> flashWpN == $past(busWrData[0]));

  p_flash_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && atFlash) |=> $stable(flashWpN));

  p_misc_only_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    atMisc |-> $countones(busRdData) <= 1 && busRdData[13:0] == '0);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRdData == '0);

  p_read_before_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && atLed) |-> busRdData[LED_W-1:0] == ledOut);

endmodule

bind sysreg_bank sysreg_bank_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LED_W  (LED_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .ledOut    (ledOut),
  .flashWpN  (flashWpN)
);

// File: tb/sysreg_bank_test.sv
`timescale 1ns/100ps
module sysreg_bank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [11:0] boardNumIn = 12'h3A5;
  logic        cardPresentIn = 1'b1;
  logic        cardWpIn = 1'b0;
  logic        masterSiteIn = 1'b1;
  logic [7:0]  ledOut;
  logic        flashWpN;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sysreg_bank uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .busRdData(busRdData), .boardNumIn(boardNumIn),
    .cardPresentIn(cardPresentIn), .cardWpIn(cardWpIn),
    .masterSiteIn(masterSiteIn), .ledOut(ledOut), .flashWpN(flashWpN)
  );

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic        chk;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,        1'b1, 32'h03A5_0100, 8'd2},  // R2 id
    '{1'b1, 12'h000, 32'hFFFF_FFFF, 1'b1, 32'h03A5_0100, 8'd2},  // R2 write
    '{1'b0, 12'h000, 32'h0,        1'b1, 32'h03A5_0100, 8'd2},  // R2 ignored
    '{1'b1, 12'h008, 32'h0000_00A5, 1'b1, 32'h0,         8'd10}, // R10 old
    '{1'b0, 12'h008, 32'h0,        1'b1, 32'h0000_00A5, 8'd3},  // R3
    '{1'b1, 12'h008, 32'hFFFF_FF3C, 1'b1, 32'h0000_00A5, 8'd10}, // R10
    '{1'b0, 12'h008, 32'h0,        1'b1, 32'h0000_003C, 8'd3},  // R3 upper
    '{1'b1, 12'h030, 32'h0000_0F0F, 1'b1, 32'h0,         8'd10}, // R10 flags
    '{1'b0, 12'h030, 32'h0,        1'b1, 32'h0000_0F0F, 8'd4},  // R4
    '{1'b1, 12'h030, 32'hF000_0001, 1'b0, 32'h0,         8'd4},  // R4
    '{1'b0, 12'h030, 32'h0,        1'b1, 32'hF000_0F0F, 8'd4},  // R4 or
    '{1'b1, 12'h034, 32'h0000_0101, 1'b1, 32'h0,         8'd5},  // R5 reads 0
    '{1'b0, 12'h030, 32'h0,        1'b1, 32'hF000_0E0E, 8'd5},  // R5 partial
    '{1'b0, 12'h034, 32'h0,        1'b1, 32'h0,         8'd5},  // R5
    '{1'b1, 12'h034, 32'hFFFF_FFFF, 1'b0, 32'h0,         8'd5},  // R5
    '{1'b0, 12'h030, 32'h0,        1'b1, 32'h0,         8'd5},  // R5 all
    '{1'b0, 12'h048, 32'h0,        1'b1, 32'h0000_0001, 8'd6},  // R6
    '{1'b1, 12'h048, 32'hFFFF_FFFF, 1'b0, 32'h0,         8'd6},  // R6
    '{1'b0, 12'h048, 32'h0,        1'b1, 32'h0000_0001, 8'd6},  // R6 ignored
    '{1'b1, 12'h04C, 32'hFFFF_FFFF, 1'b0, 32'h0,         8'd7},  // R7
    '{1'b0, 12'h04C, 32'h0,        1'b1, 32'h0000_0001, 8'd7},  // R7
    '{1'b0, 12'h060, 32'h0,        1'b1, 32'h0000_4000, 8'd8},  // R8
    '{1'b1, 12'h060, 32'hFFFF_FFFF, 1'b0, 32'h0,         8'd8},  // R8
    '{1'b0, 12'h060, 32'h0,        1'b1, 32'h0000_4000, 8'd8},  // R8 ignored
    '{1'b1, 12'h100, 32'hFFFF_FFFF, 1'b1, 32'h0,         8'd9},  // R9
    '{1'b1, 12'h00A, 32'hFFFF_FFFF, 1'b1, 32'h0,         8'd9},  // R9 unaligned
    '{1'b0, 12'h004, 32'h0,        1'b1, 32'h0,         8'd9},  // R9
    '{1'b0, 12'h008, 32'h0,        1'b1, 32'h0000_003C, 8'd9},  // R9 led intact
    '{1'b0, 12'h030, 32'h0,        1'b1, 32'h0,         8'd9},  // R9 flags intact
    '{1'b0, 12'h04C, 32'h0,        1'b1, 32'h0000_0001, 8'd9}   // R9 flash intact
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readAt(input logic [11:0] a);
    @(negedge clk);
    busWe = 1'b0; busAddr = a; busWrData = '0;
    #1;
  endtask

  task automatic finishRun;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1 led pins", {24'h0, ledOut}, 32'h0);
    check("R1 flash pin", {31'h0, flashWpN}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    readAt(12'h008); check("R1 led word", busRdData, 32'h0);
    readAt(12'h030); check("R1 flags", busRdData, 32'h0);
    readAt(12'h04C); check("R1 flash word", busRdData, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busWe = VECS[i].we; busAddr = VECS[i].addr; busWrData = VECS[i].data;
      #1;
      if (VECS[i].chk) check($sformatf("R%0d vec %0d", VECS[i].req, i), busRdData, VECS[i].exp);
    end
    @(negedge clk); busWe = 1'b0;
    #1;
    check("R3 led pins", {24'h0, ledOut}, 32'h0000_003C);
    check("R7 flash pin", {31'h0, flashWpN}, 32'h1);

    // R7: clear flash control, pin follows
    @(negedge clk); busWe = 1'b1; busAddr = 12'h04C; busWrData = 32'hFFFF_FFFE;
    @(negedge clk); busWe = 1'b0; #1;
    check("R7 flash pin low", {31'h0, flashWpN}, 32'h0);

    // R6: two-edge synchroniser latency
    @(negedge clk); busWe = 1'b0; busAddr = 12'h048; cardWpIn = 1'b1;
    @(negedge clk); #1;
    check("R6 after one edge", busRdData, 32'h1);
    @(negedge clk); #1;
    check("R6 after two edges", busRdData, 32'h3);

    // R8: master site cleared
    @(negedge clk); busAddr = 12'h060; masterSiteIn = 1'b0;
    repeat (2) @(negedge clk);
    #1; check("R8 first site", busRdData, 32'h0);

    // R2: board number change
    @(negedge clk); busAddr = 12'h000; boardNumIn = 12'hFFF;
    repeat (2) @(negedge clk);
    #1; check("R2 board field", busRdData, 32'h0FFF_0100);

    // R1: reset mid-run clears state
    @(negedge clk); busWe = 1'b1; busAddr = 12'h030; busWrData = 32'h1234_5678;
    @(negedge clk); busWe = 1'b0; rstN = 1'b0;
    #1;
    check("R1 led after reset", {24'h0, ledOut}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    readAt(12'h030); check("R1 flags after reset", busRdData, 32'h0);

    finishRun();
  end

endmodule